// File: doc/BRIEF.md
# DMA Channel Start/Done Command Registers

This block keeps two status bits for each of 16 DMA channels. A START bit asks the transfer engine to service the channel. A DONE bit records that the channel's transfer has completed. Software does not write these bits as a bitmask. Instead it writes an encoded channel number, one byte at a time, to one of two write-only command addresses: one command address sets START bits and the other clears DONE bits.

The low four bits of the command name a single channel. Bit 6 of the byte selects every channel at once. Command values in the middle range are reserved and do nothing. The transfer engine works beside the register bus. It clears a channel's START bit when it takes up that channel's request, and it sets a channel's DONE bit when the transfer finishes. Both state vectors are brought out as ports for the engine and for interrupt logic.

Top module: `dma_cmd_regs`

## Requirements
- R1: After reset, all 16 START bits and all 16 DONE bits are 0.
- R2: A write to byte offset 0x1E with command value c (c = data bits 6:0) in the range 0..15 sets START bit c. All other START bits and all DONE bits are left unchanged.
- R3: A write to byte offset 0x1F with command value c in the range 0..15 clears DONE bit c. All other DONE bits and all START bits are left unchanged.
- R4: A command value from 64 to 127 (data bit 6 set) sets all START bits when written to 0x1E. Written to 0x1F, it clears all DONE bits.
- R5: A command value from 16 to 63 is reserved. Written to either command offset, it changes no START or DONE bit.
- R6: Data bit 7 is ignored. A byte and the same byte with bit 7 inverted produce the same effect.
- R7: rdata_o is 0x00 for every read, including reads of both command offsets. No written value is kept as readable state.
- R8: A write to any address other than 0x1E or 0x1F changes no START or DONE bit.
- R9: start_clr_i[k] clears START bit k. A software set of channel k in the same cycle takes priority, so the bit ends up set.
- R10: done_set_i[k] sets DONE bit k. It takes priority over a software clear of channel k in the same cycle, so the bit ends up set.
- R11: A command takes effect on the rising clock edge at which we_i is sampled high. The new bit values appear on start_o and done_o from that edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address within the block |
| wdata_i | input | 8 | Write data byte |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, always zero |
| start_clr_i | input | 16 | Engine-side clear of START, one bit per channel |
| done_set_i | input | 16 | Engine-side set of DONE, one bit per channel |
| start_o | output | 16 | START state per channel |
| done_o | output | 16 | DONE state per channel |

## Verification
On every cycle, the assertions check the following:
- single-channel and all-channel commands land one edge later;
- an engine DONE set is never lost to a software clear;
- a software set wins over the engine's START clear;
- when no command and no engine request is present, both state vectors hold steady.

Some behaviours only the bench's scenarios can show. One is that every reserved command value and every address outside the two command offsets leaves state untouched. Another is that bit 7 has no effect. The bench shows these by sweeping all 256 data bytes against both offsets and every other address, starting from known, mixed state.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;
  localparam int unsigned NUM_CH_D   = 16;
  localparam int unsigned ADDR_W_D   = 8;
  localparam int unsigned DATA_W_D   = 8;
  localparam int unsigned CMD_W_D    = 7;  // bit CMD_W-1 = all-channels
  localparam logic [7:0]  OFF_SET_START = 8'h1E;
  localparam logic [7:0]  OFF_CLR_DONE  = 8'h1F;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_SINGLE = 2'd1,
    CMD_ALL    = 2'd2
  } cmd_kind_e;
endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_cmd_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_D,
  parameter int unsigned CMD_W  = CMD_W_D,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              valid_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic [NUM_CH-1:0] sel_o
);
  cmd_kind_e kind;
  logic [CH_W-1:0] ch_idx;

  assign ch_idx = cmd_i[CH_W-1:0];

  always_comb begin
    if (!valid_i)                       kind = CMD_NONE;
    else if (cmd_i[CMD_W-1])            kind = CMD_ALL;
    else if (cmd_i[CMD_W-2:CH_W] == '0) kind = CMD_SINGLE;
    else                                kind = CMD_NONE;  // reserved range
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_sel
    assign sel_o[k] = (kind == CMD_ALL) ||
                      ((kind == CMD_SINGLE) && (ch_idx == CH_W'(k)));
  end
endmodule

// File: rtl/dma_chan_bits.sv
module dma_chan_bits
  import dma_cmd_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] sw_set_start_i,
  input  logic [NUM_CH-1:0] hw_clr_start_i,
  input  logic [NUM_CH-1:0] sw_clr_done_i,
  input  logic [NUM_CH-1:0] hw_set_done_i,
  output logic [NUM_CH-1:0] start_o,
  output logic [NUM_CH-1:0] done_o
);
  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic start_q, done_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        start_q <= 1'b0;
        done_q  <= 1'b0;
      end else begin
        // software set beats engine clear; engine set beats software clear
        if (sw_set_start_i[k])      start_q <= 1'b1;
        else if (hw_clr_start_i[k]) start_q <= 1'b0;
        if (hw_set_done_i[k])       done_q  <= 1'b1;
        else if (sw_clr_done_i[k])  done_q  <= 1'b0;
      end
    end
    assign start_o[k] = start_q;
    assign done_o[k]  = done_q;
  end
endmodule

// File: rtl/dma_cmd_regs.sv
module dma_cmd_regs
  import dma_cmd_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_D,
  parameter int unsigned ADDR_W = ADDR_W_D,
  parameter int unsigned DATA_W = DATA_W_D,
  localparam int unsigned CMD_W = CMD_W_D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] start_clr_i,
  input  logic [NUM_CH-1:0] done_set_i,
  output logic [NUM_CH-1:0] start_o,
  output logic [NUM_CH-1:0] done_o
);
  logic hit_set, hit_clr;
  logic [NUM_CH-1:0] set_start_sel, clr_done_sel;
  logic unused_bits;

  assign hit_set = we_i && (addr_i == ADDR_W'(OFF_SET_START));
  assign hit_clr = we_i && (addr_i == ADDR_W'(OFF_CLR_DONE));

  dma_cmd_decode #(.NUM_CH(NUM_CH), .CMD_W(CMD_W)) u_dec_set (
    .valid_i (hit_set),
    .cmd_i   (wdata_i[CMD_W-1:0]),
    .sel_o   (set_start_sel)
  );

  dma_cmd_decode #(.NUM_CH(NUM_CH), .CMD_W(CMD_W)) u_dec_clr (
    .valid_i (hit_clr),
    .cmd_i   (wdata_i[CMD_W-1:0]),
    .sel_o   (clr_done_sel)
  );

  dma_chan_bits #(.NUM_CH(NUM_CH)) u_bits (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sw_set_start_i (set_start_sel),
    .hw_clr_start_i (start_clr_i),
    .sw_clr_done_i  (clr_done_sel),
    .hw_set_done_i  (done_set_i),
    .start_o        (start_o),
    .done_o         (done_o)
  );

  // command registers are write-only and hold no value
  assign rdata_o     = '0;
  assign unused_bits = ^{re_i, wdata_i[DATA_W-1:CMD_W]};
endmodule

// File: rtl/dma_cmd_regs_chk.sv
module dma_cmd_regs_chk #(
  parameter int unsigned NUM_CH = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic [NUM_CH-1:0] start_clr_i,
  input logic [NUM_CH-1:0] done_set_i,
  input logic [NUM_CH-1:0] start_o,
  input logic [NUM_CH-1:0] done_o
);
  logic wr_set, wr_clr;
  assign wr_set = we_i && (addr_i == ADDR_W'(8'h1E));
  assign wr_clr = we_i && (addr_i == ADDR_W'(8'h1F));

  p_set_all_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set && wdata_i[6] |=> (start_o == '1));

  p_set_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set && !wdata_i[6] && (wdata_i[5:4] == 2'b00) |=> start_o[$past(wdata_i[3:0])]);

  p_clr_all_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr && wdata_i[6] && (done_set_i == '0) |=> (done_o == '0));

  p_clr_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr && !wdata_i[6] && (wdata_i[5:4] == 2'b00) && !done_set_i[wdata_i[3:0]]
    |=> !done_o[$past(wdata_i[3:0])]);

  p_done_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_set_i != '0) |=> ((done_o & $past(done_set_i)) == $past(done_set_i)));

  p_start_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_set && (start_clr_i == '0) |=> $stable(start_o));

  p_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_clr && (done_set_i == '0) |=> $stable(done_o));

  p_hw_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_set && (start_clr_i != '0) |=> ((start_o & $past(start_clr_i)) == '0));
endmodule

bind dma_cmd_regs dma_cmd_regs_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .we_i        (we_i),
  .start_clr_i (start_clr_i),
  .done_set_i  (done_set_i),
  .start_o     (start_o),
  .done_o      (done_o)
);

// File: tb/tb_dma_cmd_regs.sv
module tb_dma_cmd_regs;
  localparam int NCH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic we = 1'b0;
  logic re = 1'b0;
  logic [7:0] rdata;
  logic [NCH-1:0] sclr = '0;
  logic [NCH-1:0] dset = '0;
  logic [NCH-1:0] start, done;
  logic [NCH-1:0] exp_start = '0;
  logic [NCH-1:0] exp_done = '0;
  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  dma_cmd_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata), .start_clr_i(sclr),
    .done_set_i(dset), .start_o(start), .done_o(done)
  );

  function automatic logic [NCH-1:0] sel_of(input logic [7:0] d);
    int c = int'(d) % 128;
    if (c >= 64)     return '1;
    else if (c < 16) return NCH'(1) << c;
    else             return '0;
  endfunction

  function automatic string tag_of(input logic [7:0] a, input logic [7:0] d, input bit sw);
    int c = int'(d) % 128;
    if (a != 8'h1E && a != 8'h1F) return "R8";
    if (d[7])   return "R6";
    if (c >= 64) return "R4";
    if (c >= 16) return "R5";
    return sw ? "R2" : "R3";
  endfunction

  task automatic check_state(input string tag);
    n_chk++;
    if (start !== exp_start || done !== exp_done) begin
      n_err++;
      $display("FAIL %s: start=%h done=%h expected start=%h done=%h",
               tag, start, done, exp_start, exp_done);
    end
  endtask

  // drive at negedge, model updates at posedge, compare at next negedge (R11)
  task automatic step(input logic [7:0] a, input logic [7:0] d, input logic w,
                      input logic [NCH-1:0] sc, input logic [NCH-1:0] ds,
                      input string tag);
    logic [NCH-1:0] ss, cd;
    addr = a; wdata = d; we = w; sclr = sc; dset = ds;
    ss = (w && a == 8'h1E) ? sel_of(d) : '0;
    cd = (w && a == 8'h1F) ? sel_of(d) : '0;
    @(posedge clk);
    exp_start = ss | (exp_start & ~sc);
    exp_done  = ds | (exp_done & ~cd);
    @(negedge clk);
    we = 1'b0; sclr = '0; dset = '0;
    check_state(tag);
  endtask

  task automatic preload();
    step(8'h00, 8'h00, 1'b0, 16'hFFFF, 16'hA5C3, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_state("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1");

    // sweep every byte into set-start offset
    for (int v = 0; v < 256; v++) begin
      preload();
      step(8'h1E, 8'(v), 1'b1, '0, '0, tag_of(8'h1E, 8'(v), 1'b1));
    end
    // sweep every byte into clear-done offset
    for (int v = 0; v < 256; v++) begin
      preload();
      step(8'h00, 8'h00, 1'b0, '0, 16'hFFFF, "R10");
      step(8'h1F, 8'(v), 1'b1, '0, '0, tag_of(8'h1F, 8'(v), 1'b0));
    end
    // all-channel command at every other address
    for (int a = 0; a < 256; a++) begin
      if (a == 8'h1E || a == 8'h1F) continue;
      step(8'(a), 8'h40, 1'b1, '0, '0, "R8");
    end

    // R9: software set beats engine clear
    step(8'h1E, 8'h3F, 1'b1, '0, '0, "R5");
    step(8'h1E, 8'h40, 1'b1, '0, '0, "R4");
    step(8'h1E, 8'h05, 1'b1, 16'hFFFF, '0, "R9");
    step(8'h1E, 8'hC0, 1'b1, 16'hFFFF, '0, "R9");
    step(8'h00, 8'h00, 1'b0, 16'h00F0, '0, "R9");
    // R10: engine set beats software clear
    step(8'h00, 8'h00, 1'b0, '0, 16'hFFFF, "R10");
    step(8'h1F, 8'h03, 1'b1, '0, 16'h0008, "R10");
    step(8'h1F, 8'h7F, 1'b1, '0, 16'h8001, "R10");

    // R7: reads return zero everywhere
    for (int a = 0; a < 256; a++) begin
      addr = 8'(a); re = 1'b1;
      @(posedge clk); @(negedge clk);
      n_chk++;
      if (rdata !== 8'h00) begin
        n_err++;
        $display("FAIL R7: addr=%h rdata=%h expected 00", a, rdata);
      end
    end
    re = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule